// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block turns a synchronous single-cycle request bus into the strobe sequences that a 32768 × 8 asynchronous static RAM needs. A requester pulses `req_valid` for one clock with a write flag, a 15-bit word address and, for writes, a byte of data. The controller then runs one complete memory cycle. It drives the active-low chip select, write enable and output enable. It also drives the address lines and a data bus that is split into an outgoing byte, a driver-enable and an incoming byte. When the cycle is over it raises `rsp_ready` for one clock. For a read, `rsp_rdata` then holds the byte that was captured.

The clock period is given in nanoseconds as a parameter, and so is every minimum time of the memory. Each time is rounded up to whole clock cycles, and each count is at least one cycle. Writes are controlled by write enable, and output enable stays high for the whole write. After every read the controller waits for the memory's output-release time before it will accept new work. Because of that wait, its own drivers never overlap the memory's.

Top module: `sramc_async_ctl`

## Requirements
- R1: During reset and while idle, `sram_cs_n`, `sram_we_n` and `sram_oe_n` are all 1, `sram_dq_oe` is 0 and `rsp_ready` is 0.
- R2: A read holds chip select and output enable at 0 and write enable at 1 for N_RD = max(ceil(T_RC/CLK), ceil(T_AA/CLK), ceil(T_AOE/CLK)) cycles. `sram_dq_in` is sampled at the clock edge that ends the last of these cycles and appears on `rsp_rdata` together with `rsp_ready`.
- R3: During a write, write enable is 0 for N_PULSE = max(ceil(T_WP/CLK), ceil(T_DW/CLK)) consecutive cycles. Chip select is 0 and the address is stable for at least T_CW and T_AW before write enable returns to 1, and output enable stays 1 for the whole write.
- R4: Write data is driven (`sram_dq_oe` = 1) from the first cycle of the write until one cycle after write enable rises. It is therefore valid at least T_DW before the rise and held after it.
- R5: After a read releases output enable and chip select, the controller's drivers stay off for at least ceil(T_OHZ/CLK) cycles.
- R6: `rsp_ready` is a one-cycle pulse, given once per accepted request in the first idle cycle after the memory cycle. The latency from the accepting edge is N_RD + ceil(T_OHZ/CLK) cycles for a read and N_SETUP + N_PULSE + 1 cycles for a write.
- R7: A `req_valid` pulse that arrives while a transaction is in progress is ignored: it starts no memory cycle, produces no ready pulse and changes no memory content.
- R8: Address and write data are registered when the request is accepted. Changes on `req_addr` and `req_wdata` after that edge do not reach the memory cycle.
- R9: N_SETUP = max(1, ceil(T_WC/CLK) − N_PULSE − 1, ceil(max(T_CW,T_AW)/CLK) − N_PULSE). The whole write cycle of N_SETUP + N_PULSE + 1 cycles is therefore never shorter than T_WC.
- R10: The data drivers are never enabled while output enable is 0.

Top module ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | One-cycle request strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_addr | output | ADDR_W | Memory address lines |
| sram_dq_out | output | DATA_W | Data driven toward the memory |
| sram_dq_oe | output | 1 | Enable of the controller's data drivers |
| sram_dq_in | input | DATA_W | Data returned by the memory |

## Verification
The memory model in the bench returns the inverted byte until the read access time has really passed. A controller that samples one cycle too early therefore captures wrong data at once. The model also keeps its own outputs on for the release time after each read. A write issued right after a read would show contention if the turnaround wait were shortened. At every rising edge of write enable, the model measures the pulse width, the chip-select and address hold, and the data-valid window, so a wait-state count that rounds down is reported as a violation. A second request that overwrites the address and data inputs in the middle of a write exposes a controller that accepts work while busy, or one that forwards its inputs without registering them.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_WAIT  = 3'd1,
        ST_RD_CAP   = 3'd2,
        ST_WR_SETUP = 3'd3,
        ST_WR_PULSE = 3'd4,
        ST_WR_END   = 3'd5,
        ST_TURN     = 3'd6
    } sramc_state_e;

    typedef struct packed {
        sramc_state_e st;
        logic         cs_n;
        logic         we_n;
        logic         oe_n;
        logic         drv;
        logic         rdy;
    } sramc_ctl_t;

    // Minimum time in ns to whole clock cycles, rounded up, never below one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
        int unsigned c;
        c = (ns + per - 1) / per;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sramc_wait_ctr.sv
module sramc_wait_ctr #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // An expired count stays expired until reloaded (wait states never wrap).
    assert_ctr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);

endmodule

// File: rtl/sramc_req_hold.sv
module sramc_req_hold #(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [DATA_W-1:0] data_out
);
    logic [ADDR_W-1:0] addr_d, addr_q;
    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        addr_d = addr_q;
        data_d = data_q;
        if (take) begin
            addr_d = addr_in;
            data_d = data_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else begin
            addr_q <= addr_d;
            data_q <= data_d;
        end
    end

    assign addr_out = addr_q;
    assign data_out = data_q;

endmodule

// File: rtl/sramc_rd_cap.sv
module sramc_rd_cap #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = cap ? dq_in : rdata_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/sramc_async_ctl.sv
module sramc_async_ctl
    import sramc_pkg::*;
#(
    parameter int unsigned CLK_NS   = 10,
    parameter int unsigned ADDR_W   = 15,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned T_RC_NS  = 70,
    parameter int unsigned T_AA_NS  = 70,
    parameter int unsigned T_AOE_NS = 35,
    parameter int unsigned T_WC_NS  = 70,
    parameter int unsigned T_WP_NS  = 50,
    parameter int unsigned T_CW_NS  = 50,
    parameter int unsigned T_AW_NS  = 50,
    parameter int unsigned T_DW_NS  = 30,
    parameter int unsigned T_OHZ_NS = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              sram_cs_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);
    // Wait-state counts derived from the timing parameters.
    localparam int unsigned N_RD    = umax(ns_to_cyc(T_RC_NS, CLK_NS),
                                      umax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_AOE_NS, CLK_NS)));
    localparam int unsigned N_PULSE = umax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS));
    localparam int unsigned N_WC    = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int unsigned N_HOLD  = ns_to_cyc(umax(T_CW_NS, T_AW_NS), CLK_NS);
    localparam int unsigned WC_REM  = (N_WC > N_PULSE + 1) ? (N_WC - N_PULSE - 1) : 0;
    localparam int unsigned HD_REM  = (N_HOLD > N_PULSE) ? (N_HOLD - N_PULSE) : 0;
    localparam int unsigned N_SETUP = umax(1, umax(WC_REM, HD_REM));
    localparam int unsigned N_TA    = ns_to_cyc(T_OHZ_NS, CLK_NS);
    localparam int unsigned N_MAX   = umax(umax(N_RD, N_PULSE), umax(N_SETUP, N_TA));
    localparam int unsigned CNT_W   = $clog2(N_MAX + 1);
    localparam int unsigned GAP_W   = $clog2(N_TA + 1);

    localparam logic [CNT_W-1:0] LD_RD    = (N_RD > 1) ? CNT_W'(N_RD - 2) : '0;
    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(N_SETUP - 1);
    localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(N_PULSE - 1);
    localparam logic [CNT_W-1:0] LD_TA    = CNT_W'(N_TA - 1);
    localparam logic [GAP_W-1:0] GAP_MIN  = GAP_W'(N_TA);

    sramc_ctl_t        ctl_d, ctl_q;
    logic              ld;
    logic [CNT_W-1:0]  ld_val;
    logic              wait_zero;
    logic              take;
    logic              cap;

    sramc_wait_ctr #(.CNT_W(CNT_W)) wait_ctr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .zero     (wait_zero)
    );

    sramc_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) req_hold_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .addr_in  (req_addr),
        .data_in  (req_wdata),
        .addr_out (sram_addr),
        .data_out (sram_dq_out)
    );

    sramc_rd_cap #(.DATA_W(DATA_W)) rd_cap_i (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (cap),
        .dq_in (sram_dq_in),
        .rdata (rsp_rdata)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.rdy = 1'b0;
        ld        = 1'b0;
        ld_val    = '0;
        take      = 1'b0;
        cap       = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    take = 1'b1;
                    ld   = 1'b1;
                    if (req_write) begin
                        ctl_d.st = ST_WR_SETUP;
                        ld_val   = LD_SETUP;
                    end else if (N_RD > 1) begin
                        ctl_d.st = ST_RD_WAIT;
                        ld_val   = LD_RD;
                    end else begin
                        ctl_d.st = ST_RD_CAP;
                    end
                end
            end
            ST_RD_WAIT: begin
                if (wait_zero) ctl_d.st = ST_RD_CAP;
            end
            ST_RD_CAP: begin
                cap      = 1'b1;
                ld       = 1'b1;
                ld_val   = LD_TA;
                ctl_d.st = ST_TURN;
            end
            ST_TURN: begin
                if (wait_zero) begin
                    ctl_d.st  = ST_IDLE;
                    ctl_d.rdy = 1'b1;
                end
            end
            ST_WR_SETUP: begin
                if (wait_zero) begin
                    ld       = 1'b1;
                    ld_val   = LD_PULSE;
                    ctl_d.st = ST_WR_PULSE;
                end
            end
            ST_WR_PULSE: begin
                if (wait_zero) ctl_d.st = ST_WR_END;
            end
            ST_WR_END: begin
                ctl_d.st  = ST_IDLE;
                ctl_d.rdy = 1'b1;
            end
            default: ctl_d.st = ST_IDLE;
        endcase

        // Strobes are registered, decoded from the state being entered.
        ctl_d.cs_n = (ctl_d.st == ST_IDLE) || (ctl_d.st == ST_TURN);
        ctl_d.oe_n = !((ctl_d.st == ST_RD_WAIT) || (ctl_d.st == ST_RD_CAP));
        ctl_d.we_n = (ctl_d.st != ST_WR_PULSE);
        ctl_d.drv  = (ctl_d.st == ST_WR_SETUP) || (ctl_d.st == ST_WR_PULSE) ||
                     (ctl_d.st == ST_WR_END);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0, rdy: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sram_cs_n  = ctl_q.cs_n;
    assign sram_we_n  = ctl_q.we_n;
    assign sram_oe_n  = ctl_q.oe_n;
    assign sram_dq_oe = ctl_q.drv;
    assign rsp_ready  = ctl_q.rdy;

    // Checker state: cycles since output enable was last low, saturating.
    logic [GAP_W-1:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              gap_q <= GAP_MIN;
        else if (!sram_oe_n)     gap_q <= '0;
        else if (gap_q < GAP_MIN) gap_q <= gap_q + 1'b1;
    end

    assert_turn_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> (gap_q >= GAP_MIN));

    assert_drv_oe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_oe_n);

    assert_we_in_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_cs_n && sram_oe_n && sram_dq_oe));

    assert_rdy_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |=> !rsp_ready);

    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));

    assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> sram_dq_oe && $stable(sram_dq_out));

endmodule

// File: tb/sramc_async_ctl_tb_top.sv
module sramc_async_ctl_tb_top;
    localparam int unsigned CLK_NS = 10;
    localparam int unsigned T_RC = 70, T_AA = 70, T_AOE = 35, T_WC = 70;
    localparam int unsigned T_WP = 50, T_CW = 50, T_AW = 50, T_DW = 30, T_OHZ = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_ready;
    logic [7:0]  rsp_rdata;
    logic        sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [14:0] sram_addr;
    logic [7:0]  sram_dq_out;
    logic [7:0]  sram_dq_in = '0;

    always #5 clk = ~clk;

    sramc_async_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ready(rsp_ready),
        .rsp_rdata(rsp_rdata), .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .sram_addr(sram_addr), .sram_dq_out(sram_dq_out),
        .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    function automatic int unsigned cdiv(input int unsigned ns);
        int unsigned c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int unsigned mx(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    int unsigned e_rd, e_pulse, e_setup, e_ta;
    int unsigned total = 0, passed = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (ok) passed++;
        else $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    endtask

    // ---------------- behavioural memory with timing checks ----------------
    logic [7:0]  mdl [int unsigned];
    logic [7:0]  ref_mem [int unsigned];
    int unsigned cs_cnt, oe_cnt, we_cnt, dat_cnt, hold;
    int unsigned p_cs_cnt, p_we_cnt, p_dat_cnt;
    logic        p_we_low;
    logic [14:0] p_addr;
    logic [7:0]  p_dout;
    int unsigned viol = 0, contention = 0, oe_clash = 0, wr_seen = 0;

    function automatic logic [7:0] rdm(input logic [14:0] a);
        return mdl.exists(int'(a)) ? mdl[int'(a)] : 8'h00;
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            cs_cnt = 0; oe_cnt = 0; we_cnt = 0; dat_cnt = 0; hold = 0;
            p_cs_cnt = 0; p_we_cnt = 0; p_dat_cnt = 0; p_we_low = 1'b0;
            p_addr = '0; p_dout = '0;
        end else begin
            if (p_we_low && sram_we_n) begin
                wr_seen++;
                if (p_we_cnt * CLK_NS < T_WP) viol++;
                if (p_cs_cnt * CLK_NS < mx(T_CW, T_AW)) viol++;
                if (p_dat_cnt * CLK_NS < T_DW) viol++;
                mdl[int'(p_addr)] = p_dout;
            end
            if (p_we_low && (sram_addr != p_addr || sram_cs_n)) viol++;
            cs_cnt  = sram_cs_n ? 0 : ((p_cs_cnt > 0 && sram_addr == p_addr) ? p_cs_cnt + 1 : 1);
            oe_cnt  = (!sram_cs_n && !sram_oe_n) ? oe_cnt + 1 : 0;
            we_cnt  = !sram_we_n ? p_we_cnt + 1 : 0;
            if (!sram_we_n && (sram_cs_n || !sram_dq_oe)) viol++;
            dat_cnt = !sram_dq_oe ? 0 : ((p_dat_cnt > 0 && sram_dq_out == p_dout) ? p_dat_cnt + 1 : 1);
            if (sram_dq_oe && !sram_oe_n) oe_clash++;
            if (sram_dq_oe && ((!sram_cs_n && !sram_oe_n && sram_we_n) || hold > 0)) contention++;
            if (!sram_cs_n && !sram_oe_n && sram_we_n) begin
                hold = cdiv(T_OHZ);
                if (cs_cnt * CLK_NS >= mx(T_AA, T_RC) && oe_cnt * CLK_NS >= T_AOE)
                    sram_dq_in = rdm(sram_addr);
                else
                    sram_dq_in = ~rdm(sram_addr);
            end else begin
                if (hold > 0) hold--;
                sram_dq_in = 8'h00;
            end
            p_cs_cnt = cs_cnt; p_we_cnt = we_cnt; p_dat_cnt = dat_cnt;
            p_we_low = !sram_we_n; p_addr = sram_addr; p_dout = sram_dq_out;
        end
    end

    // ---------------- transaction task ----------------
    task automatic xfer(input bit wr, input logic [14:0] a, input logic [7:0] d,
                        output logic [7:0] rd, output int lat, output logic rdy_after);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_addr = 15'($urandom); req_wdata = 8'($urandom);
        lat = 0;
        while (!rsp_ready && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        rd = rsp_rdata;
        @(negedge clk);
        rdy_after = rsp_ready;
        if (wr) ref_mem[int'(a)] = d;
    endtask

    function automatic logic [7:0] ref_rd(input logic [14:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
    endfunction

    task automatic wr_rd(input logic [14:0] a, input logic [7:0] d, input logic [14:0] ra);
        logic [7:0] rd; int lat; logic ra_rdy;
        xfer(1'b1, a, d, rd, lat, ra_rdy);
        chk(lat == int'(e_setup + e_pulse + 1), "R9 write latency", lat, e_setup + e_pulse + 1);
        chk(!ra_rdy, "R6 ready one cycle after write", ra_rdy, 0);
        xfer(1'b0, ra, 8'h00, rd, lat, ra_rdy);
        chk(lat == int'(e_rd + e_ta), "R2 read latency", lat, e_rd + e_ta);
        chk(rd == ref_rd(ra), "R2 R4 read data", rd, ref_rd(ra));
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", passed, total);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] rd; int lat; logic ra_rdy; int unsigned seed; int pulses; logic addr_ok;
        e_rd    = mx(cdiv(T_RC), mx(cdiv(T_AA), cdiv(T_AOE)));
        e_pulse = mx(cdiv(T_WP), cdiv(T_DW));
        e_setup = mx(1, mx((cdiv(T_WC) > e_pulse + 1) ? cdiv(T_WC) - e_pulse - 1 : 0,
                           (cdiv(mx(T_CW, T_AW)) > e_pulse) ? cdiv(mx(T_CW, T_AW)) - e_pulse : 0));
        e_ta    = cdiv(T_OHZ);
        seed = $urandom(32'd2024);

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(sram_cs_n && sram_we_n && sram_oe_n, "R1 strobes high in reset",
            {sram_cs_n, sram_we_n, sram_oe_n}, 3'b111);
        chk(!sram_dq_oe, "R1 drivers off in reset", sram_dq_oe, 0);
        chk(!rsp_ready, "R1 ready low in reset", rsp_ready, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe, "R1 idle after reset",
            {sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe}, 4'b1110);

        // Directed corners: lowest and highest address, unwritten read
        xfer(1'b0, 15'h1234, 8'h00, rd, lat, ra_rdy);
        chk(rd == 8'h00, "R2 unwritten read", rd, 0);
        wr_rd(15'h0000, 8'hA5, 15'h0000);
        wr_rd(15'h7FFF, 8'h3C, 15'h7FFF);
        wr_rd(15'h7FFE, 8'hFF, 15'h0000);

        // R7/R8: second request and changed inputs during a write
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h0155; req_wdata = 8'h66;
        @(negedge clk);
        req_valid = 1'b0; req_addr = 15'h0AAA; req_wdata = 8'h99;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        pulses = 0; addr_ok = 1'b1;
        for (int i = 0; i < 30; i++) begin
            if (rsp_ready) pulses++;
            if (!sram_cs_n && sram_addr != 15'h0155) addr_ok = 1'b0;
            @(negedge clk);
        end
        ref_mem[32'h155] = 8'h66;
        chk(pulses == 1, "R7 one ready pulse for busy-time requests", pulses, 1);
        chk(addr_ok, "R8 address held from acceptance", addr_ok, 1);
        xfer(1'b0, 15'h0155, 8'h00, rd, lat, ra_rdy);
        chk(rd == 8'h66, "R8 registered write data", rd, 8'h66);
        xfer(1'b0, 15'h0AAA, 8'h00, rd, lat, ra_rdy);
        chk(rd == 8'h00, "R7 ignored write left no trace", rd, 0);

        // Constrained random: write then read back a written address
        for (int n = 0; n < 40; n++) begin
            logic [14:0] a; logic [7:0] d;
            a = 15'($urandom);
            d = 8'($urandom);
            wr_rd(a, d, ($urandom % 3 == 0) ? 15'h7FFF : a);
        end

        repeat (5) @(negedge clk);
        chk(viol == 0, "R3 R4 R9 write timing violations", viol, 0);
        chk(contention == 0, "R5 bus contention after read", contention, 0);
        chk(oe_clash == 0, "R10 drivers on with output enable low", oe_clash, 0);
        chk(wr_seen == 44, "R7 memory write count", wr_seen, 44);
        finish_run();
    end
endmodule